// File: doc/BRIEF.md
# Audio Codec Power-Up Sequencer

This block brings a stereo audio codec and a digital audio receiver out of power-up without audible clicks. After reset it walks a fixed list of codec register writes. Each write is packed into a 16-bit control word: a 7-bit register number sits above a 9-bit value. The word leaves as a high byte and a low byte, with a fixed device address, on a valid/ready byte-pair interface. That interface stands in for a two-wire bus engine outside the block.

Every accepted codec write is also stored in a shadow register file. Any codec register can be read back combinationally through a small index/data port.

The codec writes fall into two groups, separated by a settling wait:
- The first group mutes the signal paths, powers the analog blocks (headphones excepted) and resets the codec.
- The second group configures clocking and interfaces, sets attenuation and routing, and finally unmutes.

After the last codec write, the receiver reset line is held high for a timed interval. The receiver is then configured with five register writes. Each is a 24-bit SPI frame: device write byte, register number, data. A sticky done flag marks the end of the sequence. The settling wait, the reset length and the SPI half-period are parameters given in clock cycles.

Top module: `codec_boot_seq`

## Requirements
- R1: Each codec word is {reg[6:0], val[8:0]}. `cw_hi` carries bits 15:8 and `cw_lo` carries bits 7:0. `cw_addr` reads 0x34 whenever `cw_valid` is high.
- R2: A word transfers on a clock edge where `cw_valid` and `cw_ready` are both high. While `cw_ready` is low, `cw_valid` stays high and `cw_hi`/`cw_lo` hold their values. `cw_ready` may be held low for any number of cycles.
- R3: The first group transfers these words in this order: 0x15←0x0C0, 0x08←0x001, 0x07←0x000, 0x0D←0x008, 0x17←0x000.
- R4: After the fifth transfer, `cw_valid` stays low for exactly SETTLE_CYC cycles before the sixth word is offered.
- R5: The second group transfers these words in this order:
  - 0x0C, 0x0A and 0x0B each ←0x022;
  - 0x07←0x090, 0x16←0x001;
  - 0x00 and 0x01 each ←0x179;
  - 0x03←0x000, 0x03←0x100, 0x04←0x000, 0x04←0x100;
  - 0x06, 0x09, 0x0E and 0x0F each ←0x000;
  - 0x08←0x000, 0x15←0x003.
- R6: After the 22nd transfer, `rx_rst` is high for exactly RST_CYC cycles. While it is high, `cw_valid` is low and `spi_cs_n` is high.
- R7: Receiver frames follow `rx_rst` in this order: (0x04, 0x80), (0x05, 0x05), (0x01, 0x00), (0x02, 0x00), (0x03, 0x00).
  - Each frame holds `spi_cs_n` low for 24 bits: 0x20, then the register number, then the data, MSB first.
  - `spi_mosi` is valid on each rising `spi_sclk`. Each `spi_sclk` level lasts SPI_HALF cycles.
  - `spi_cs_n` stays high for at least one cycle between frames.
- R8: `rd_data` returns the 9-bit value last accepted for register `rd_idx`, with no clock delay. It reads 0 after reset. It reads 0 for any index above 0x17.
- R9: `done` rises only after the fifth frame ends with `spi_cs_n` high. Once high, it stays high, and `cw_valid` and `rx_rst` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | output | 1 | Codec word offered |
| cw_ready | input | 1 | Downstream accepts the codec word |
| cw_addr | output | 8 | Codec device address (0x34) |
| cw_hi | output | 8 | Control word high byte |
| cw_lo | output | 8 | Control word low byte |
| rx_rst | output | 1 | Receiver reset, active high |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to receiver |
| rd_idx | input | 5 | Shadow register index |
| rd_data | output | 9 | Shadow register contents |
| done | output | 1 | Sequence complete |

## Verification
The bench holds `cw_ready` low from reset and then throttles it in a two-of-three pattern. A sequencer that advanced without a handshake would skip words, and one that changed the word while stalled would corrupt it. Both show up as miscompares against the 27-entry expected list.

The bench counts the idle cycles at the group boundary and the high cycles of `rx_rst`. An off-by-one counter would miss either count by a cycle. It also checks that reset begins only after all 22 codec words.

On the SPI side, a shifter that dropped a bit or ran one bit long would report a frame width other than 24. It would also misplace every byte.

Finally, the bench reads back the shadow registers that were written twice. They must hold their second value (0x100). Registers that never change must read 0, and an out-of-range index must return 0.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

  typedef enum logic [2:0] {
    ST_CW, ST_SETTLE, ST_RST, ST_SPI_GO, ST_SPI_WAIT, ST_DONE
  } seq_state_t;

  localparam int REG_W       = 7;
  localparam int VAL_W       = 9;
  localparam int WORD_W      = REG_W + VAL_W;
  localparam int CODEC_STEPS = 22;
  localparam int GROUP1_LAST = 4;
  localparam int RX_STEPS    = 5;
  localparam int SHADOW_N    = 24;
  localparam int CIDX_W      = $clog2(CODEC_STEPS);
  localparam int SIDX_W      = $clog2(RX_STEPS);

  function automatic logic [WORD_W-1:0] pack_cw(input logic [REG_W-1:0] r,
                                                input logic [VAL_W-1:0] v);
    return {r, v};
  endfunction

  // codec write list; entries 0..4 form the pop-suppression group
  function automatic logic [WORD_W-1:0] codec_step(input logic [CIDX_W-1:0] i);
    case (i)
      5'd0:    return pack_cw(7'h15, 9'h0C0);
      5'd1:    return pack_cw(7'h08, 9'h001);
      5'd2:    return pack_cw(7'h07, 9'h000);
      5'd3:    return pack_cw(7'h0D, 9'h008);
      5'd4:    return pack_cw(7'h17, 9'h000);
      5'd5:    return pack_cw(7'h0C, 9'h022);
      5'd6:    return pack_cw(7'h0A, 9'h022);
      5'd7:    return pack_cw(7'h0B, 9'h022);
      5'd8:    return pack_cw(7'h07, 9'h090);
      5'd9:    return pack_cw(7'h16, 9'h001);
      5'd10:   return pack_cw(7'h00, 9'h179);
      5'd11:   return pack_cw(7'h01, 9'h179);
      5'd12:   return pack_cw(7'h03, 9'h000);
      5'd13:   return pack_cw(7'h03, 9'h100);
      5'd14:   return pack_cw(7'h04, 9'h000);
      5'd15:   return pack_cw(7'h04, 9'h100);
      5'd16:   return pack_cw(7'h06, 9'h000);
      5'd17:   return pack_cw(7'h09, 9'h000);
      5'd18:   return pack_cw(7'h0E, 9'h000);
      5'd19:   return pack_cw(7'h0F, 9'h000);
      5'd20:   return pack_cw(7'h08, 9'h000);
      default: return pack_cw(7'h15, 9'h003);
    endcase
  endfunction

  // receiver {register, data} pairs
  function automatic logic [15:0] rx_step(input logic [SIDX_W-1:0] i);
    case (i)
      3'd0:    return 16'h0480;
      3'd1:    return 16'h0505;
      3'd2:    return 16'h0100;
      3'd3:    return 16'h0200;
      default: return 16'h0300;
    endcase
  endfunction

endpackage

// File: rtl/codec_shadow.sv
module codec_shadow #(
  parameter int N     = 24,
  parameter int IDX_W = 5,
  parameter int VAL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VAL_W-1:0] rd_val
);
  logic [VAL_W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        regs[g] <= wr_val;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N; k++)
      if (rd_idx == IDX_W'(k)) rd_val = regs[k];
  end
endmodule

// File: rtl/codec_spi_tx.sv
module codec_spi_tx #(
  parameter int HALF    = 4,
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  output logic               fin
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(FRAME_W);

  logic               active, hi;
  logic [HW-1:0]      ph;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; hi <= 1'b0; ph <= '0; bitn <= '0; sh <= '0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1; sh <= frame; bitn <= '0; ph <= '0; hi <= 1'b0;
        end
      end else if (ph == HW'(HALF-1)) begin
        ph <= '0;
        if (!hi) begin
          hi <= 1'b1;
        end else begin
          hi <= 1'b0;
          sh <= sh << 1;
          if (bitn == BW'(FRAME_W-1)) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
          end
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign cs_n = !active;
  assign sclk = active && hi;
  assign mosi = active && sh[FRAME_W-1];
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import codec_boot_pkg::*;
#(
  parameter int         SETTLE_CYC = 2500000,
  parameter int         RST_CYC    = 1250000,
  parameter int         SPI_HALF   = 4,
  parameter logic [7:0] CODEC_ADDR = 8'h34,
  parameter logic [7:0] RX_DEV     = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       cw_valid,
  input  logic       cw_ready,
  output logic [7:0] cw_addr,
  output logic [7:0] cw_hi,
  output logic [7:0] cw_lo,
  output logic       rx_rst,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic [4:0] rd_idx,
  output logic [8:0] rd_data,
  output logic       done
);
  localparam int WMAX   = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int WAIT_W = $clog2(WMAX + 1);

  seq_state_t        state;
  logic [CIDX_W-1:0] cidx;
  logic [SIDX_W-1:0] sidx;
  logic [WAIT_W-1:0] wcnt;
  logic [WORD_W-1:0] word;
  logic              xfer, spi_fin;

  assign word     = codec_step(cidx);
  assign cw_valid = (state == ST_CW);
  assign cw_addr  = CODEC_ADDR;
  assign cw_hi    = word[WORD_W-1:8];
  assign cw_lo    = word[7:0];
  assign xfer     = cw_valid && cw_ready;
  assign rx_rst   = (state == ST_RST);
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CW; cidx <= '0; sidx <= '0; wcnt <= '0;
    end else begin
      case (state)
        ST_CW: if (xfer) begin
          if (cidx == CIDX_W'(GROUP1_LAST)) begin
            state <= ST_SETTLE; wcnt <= '0; cidx <= cidx + 1'b1;
          end else if (cidx == CIDX_W'(CODEC_STEPS-1)) begin
            state <= ST_RST; wcnt <= '0;
          end else begin
            cidx <= cidx + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (wcnt == WAIT_W'(SETTLE_CYC-1)) state <= ST_CW;
          wcnt <= wcnt + 1'b1;
        end
        ST_RST: begin
          if (wcnt == WAIT_W'(RST_CYC-1)) state <= ST_SPI_GO;
          wcnt <= wcnt + 1'b1;
        end
        ST_SPI_GO: state <= ST_SPI_WAIT;
        ST_SPI_WAIT: if (spi_fin) begin
          if (sidx == SIDX_W'(RX_STEPS-1)) state <= ST_DONE;
          else begin
            sidx  <= sidx + 1'b1;
            state <= ST_SPI_GO;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  codec_shadow #(.N(SHADOW_N), .IDX_W(5), .VAL_W(VAL_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(xfer),
    .wr_idx(word[VAL_W+4:VAL_W]), .wr_val(word[VAL_W-1:0]),
    .rd_idx(rd_idx), .rd_val(rd_data)
  );

  codec_spi_tx #(.HALF(SPI_HALF), .FRAME_W(24)) u_spi (
    .clk(clk), .rst_n(rst_n), .start(state == ST_SPI_GO),
    .frame({RX_DEV & 8'hFE, rx_step(sidx)}),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .fin(spi_fin)
  );
endmodule

// File: rtl/codec_boot_chk.sv
module codec_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cw_valid,
  input logic       cw_ready,
  input logic [7:0] cw_hi,
  input logic [7:0] cw_lo,
  input logic       rx_rst,
  input logic       spi_cs_n,
  input logic       done
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid && $stable({cw_hi, cw_lo}));

  p_quiet_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |-> !cw_valid && spi_cs_n);

  p_no_spi_in_codec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid |-> spi_cs_n);

  p_frame_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cw_valid && spi_cs_n && !rx_rst);
endmodule

bind codec_boot_seq codec_boot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
  .cw_hi(cw_hi), .cw_lo(cw_lo), .rx_rst(rx_rst), .spi_cs_n(spi_cs_n),
  .done(done)
);

// File: tb/codec_boot_seq_bench.sv
module codec_boot_seq_bench;
  localparam int SETTLE = 20;
  localparam int RSTC   = 50;
  localparam int HALF   = 2;
  localparam int NV     = 27;

  localparam logic [23:0] EXP [NV] = '{
    24'h342AC0, 24'h341001, 24'h340E00, 24'h341A08, 24'h342E00,
    24'h341822, 24'h341422, 24'h341622, 24'h340E90, 24'h342C01,
    24'h340179, 24'h340379, 24'h340600, 24'h340700, 24'h340800,
    24'h340900, 24'h340C00, 24'h341200, 24'h341C00, 24'h341E00,
    24'h341000, 24'h342A03,
    24'h200480, 24'h200505, 24'h200100, 24'h200200, 24'h200300};

  logic clk = 1'b0, rst_n = 1'b0, cw_ready = 1'b0;
  logic [4:0] rd_idx = '0;
  logic cw_valid, rx_rst, spi_cs_n, spi_sclk, spi_mosi, done;
  logic [7:0] cw_addr, cw_hi, cw_lo;
  logic [8:0] rd_data;

  always #2 clk = ~clk;

  codec_boot_seq #(.SETTLE_CYC(SETTLE), .RST_CYC(RSTC), .SPI_HALF(HALF)) u_codec_boot_seq (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_addr(cw_addr), .cw_hi(cw_hi), .cw_lo(cw_lo), .rx_rst(rx_rst),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done));

  int checks = 0, fails = 0, cyc = 0, n_got = 0;
  int settle_cnt = 0, rst_cnt = 0, rst_seen_at = -1;
  int bad_bits = 0, bad_half = 0, hi_len = 0, bits = 0;
  logic hold_low = 1'b1, prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [23:0] got [32];
  logic [23:0] frame = '0;

  task automatic check(input logic ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // stimulus of cw_ready plus bus monitors, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      cw_ready = hold_low ? 1'b0 : ((cyc % 3) != 0);
      if (rst_n) begin
        if (cw_valid && cw_ready && n_got < 32) begin
          got[n_got] = {cw_addr, cw_hi, cw_lo};
          n_got++;
        end
        if (n_got == 5 && !cw_valid) settle_cnt++;
        if (rx_rst) begin
          if (rst_seen_at < 0) rst_seen_at = n_got;
          rst_cnt++;
        end
        if (!spi_cs_n && spi_sclk && !prev_sclk) begin
          frame = {frame[22:0], spi_mosi};
          bits++;
        end
        if (!spi_sclk && prev_sclk && hi_len != HALF) bad_half++;
        hi_len = spi_sclk ? hi_len + 1 : 0;
        if (spi_cs_n && !prev_cs) begin
          if (bits != 24) bad_bits++;
          if (n_got < 32) begin
            got[n_got] = frame;
            n_got++;
          end
          bits = 0; frame = '0;
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    rd_idx = 5'h15; #1;
    check(cw_valid === 1'b1, "R2 valid after reset", 32'(cw_valid), 1);
    check({cw_addr, cw_hi, cw_lo} === 24'h342AC0, "R1 first word format",
          32'({cw_addr, cw_hi, cw_lo}), 32'h342AC0);
    check(done === 1'b0 && rx_rst === 1'b0 && spi_cs_n === 1'b1,
          "R9 reset outputs idle", {29'd0, done, rx_rst, spi_cs_n}, 1);
    check(rd_data === 9'h000, "R8 shadow zero after reset", 32'(rd_data), 0);
    repeat (4) @(negedge clk); #1;
    check(cw_valid === 1'b1 && {cw_hi, cw_lo} === 16'h2AC0 && n_got == 0,
          "R2 word held under back-pressure", 32'({cw_hi, cw_lo}), 32'h2AC0);
    hold_low = 1'b0;

    while (!done && cyc < 20000) @(negedge clk);
    if (!done) check(1'b0, "R9 watchdog expired", 32'(cyc), 20000);
    #1;

    for (int i = 0; i < NV; i++) begin
      if (i < 5)
        check(got[i] === EXP[i], $sformatf("R3 codec word %0d", i), 32'(got[i]), 32'(EXP[i]));
      else if (i < 22)
        check(got[i] === EXP[i], $sformatf("R5 codec word %0d", i), 32'(got[i]), 32'(EXP[i]));
      else
        check(got[i] === EXP[i], $sformatf("R7 spi frame %0d", i - 22), 32'(got[i]), 32'(EXP[i]));
    end
    check(n_got == NV, "R9 transaction count at done", 32'(n_got), NV);
    check(settle_cnt == SETTLE, "R4 settle gap cycles", 32'(settle_cnt), SETTLE);
    check(rst_cnt == RSTC, "R6 reset pulse cycles", 32'(rst_cnt), RSTC);
    check(rst_seen_at == 22, "R6 reset after last codec word", 32'(rst_seen_at), 22);
    check(bad_bits == 0, "R7 frames of 24 bits", 32'(bad_bits), 0);
    check(bad_half == 0, "R7 sclk high width", 32'(bad_half), 0);
    check(spi_cs_n === 1'b1, "R9 cs_n high at done", 32'(spi_cs_n), 1);
    repeat (5) @(negedge clk); #1;
    check(done === 1'b1 && cw_valid === 1'b0, "R9 done sticky", 32'(done), 1);

    rd_idx = 5'h03; #1; check(rd_data === 9'h100, "R8 shadow reg 03", 32'(rd_data), 32'h100);
    rd_idx = 5'h04; #1; check(rd_data === 9'h100, "R8 shadow reg 04", 32'(rd_data), 32'h100);
    rd_idx = 5'h15; #1; check(rd_data === 9'h003, "R8 shadow reg 15", 32'(rd_data), 32'h003);
    rd_idx = 5'h00; #1; check(rd_data === 9'h179, "R8 shadow reg 00", 32'(rd_data), 32'h179);
    rd_idx = 5'h0D; #1; check(rd_data === 9'h008, "R8 shadow reg 0D", 32'(rd_data), 32'h008);
    rd_idx = 5'h02; #1; check(rd_data === 9'h000, "R8 unwritten reg 02", 32'(rd_data), 0);
    rd_idx = 5'h18; #1; check(rd_data === 9'h000, "R8 index above range", 32'(rd_data), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule